// File: doc/BRIEF.md
# Four-Channel PS/2 Host Shift Controller

This block is a PS/2 host peripheral in which one shift engine serves four PS/2 ports. Every port has an open-drain clock line and an open-drain data line. The block never drives a line high: it only pulls lines low, and the board pulls them high. Software reaches six byte-wide registers through a simple write strobe and a combinational read port.

In receive mode the engine waits for a start bit on any port whose clock it has released. It then locks onto that port and shifts in a device-clocked frame: eight data bits, LSB first, then an odd parity bit and a stop bit. It reports the port it serves as an encoded field and flags parity and framing errors. In transmit mode software loads a byte and makes a request-to-send on one port by pulling that port's data line low while its clock is released. The engine then puts the byte, the parity bit and the stop bit on the device's clock edges and waits for the device's acknowledge.

The start and end flags are sticky. They clear only when software pulls all four clock lines low or disables the engine. Both conditions hold the engine in reset. An interrupt line reports each flag whose enable bit is set.

Top module: `ps2q_host`

## Requirements
- R1: After reset, status, control and interrupt-enable read 0x00 and the output-signal register reads 0x47. All four clock lines are pulled low, no data line is pulled low, and `irq` and `pullup_en` are low.
- R2: Registers sit at offset 0x0 (data), 0x2 (status), 0x4 (control), 0x6 (output signals), 0x8 (input signals, read-only) and 0xA (interrupt enable). In the output-signal register, bits 2:0 are the data lines of ports 0-2, bits 5:3 the clocks of ports 0-2, bit 6 the port 3 data line and bit 7 the port 3 clock. A 0 in a clock bit holds that clock line low, and a 0 in a data bit pulls that data line low.
- R3: The input-signal register returns the synchronized line levels in the output-signal bit layout.
- R4: Receive mode (control bit 1 = 0, control bit 0 = 1) takes an 11-bit frame sampled on falling clock edges: start 0, eight data bits LSB first, parity, stop. On the stop edge, status bit 1 (end) sets and the data register takes the byte. Status bits 5:3 give 1, 2, 4 or 5 for ports 0, 1, 2 or 3.
- R5: Parity is odd over the data byte. A wrong parity bit sets status bit 2, and the byte is still stored if the stop bit is high.
- R6: A low stop bit sets status bit 6 and leaves the data register unchanged.
- R7: Status bit 0 (start) sets when the start bit is detected and stays set. While all four clock bits are 0 or control bit 0 is 0, the engine is held idle and status reads 0x00.
- R8: Once a start bit has been taken on one port, activity on every other port is ignored until the engine is reset. If start edges arrive on several ports in the same cycle, the lowest-numbered port wins.
- R9: In transmit mode (control bit 1 = 1), a port whose clock bit is 1 and data bit is 0 starts on its first falling clock edge. The engine then owns that data line and presents the data LSB first, then odd parity, then stop (released), changing the level after each falling edge. The eleventh falling edge sets status bit 1, and the line stays released afterwards.
- R10: `irq` is high when (status bit 0 and enable bit 0) or (status bit 1 and enable bit 1).
- R11: Control bits 6:4 select the debounce length for the clock and data inputs: codes 0-5 give 1, 2, 4, 8, 16 or 32 cycles, and codes 6 and 7 give 32. A level held for less than the selected length is ignored.
- R12: Control bit 7 drives `pullup_en`. Control bits 3:2 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ps2_clk_in | input | 4 | Clock line levels, one per port |
| ps2_dat_in | input | 4 | Data line levels, one per port |
| ps2_clk_low | output | 4 | Pull clock line low, one per port |
| ps2_dat_low | output | 4 | Pull data line low, one per port |
| pullup_en | output | 1 | Weak pull-up enable for the pads |
| irq | output | 1 | Interrupt request |

## Verification
Two ports can both present a start bit on the same debounced falling edge, so arbitration and channel capture fall in the same cycle. The bench drives one byte on ports 1 and 3 with identical timing, so both edges arrive together. It then expects the port field to read code 2 and the stored byte to be intact. A second case finishes a frame on port 2 and then sends a full frame on port 0 without resetting the engine. The bench judges that case by an unchanged status and data register.

// File: rtl/ps2q_pkg.sv
package ps2q_pkg;
    localparam int NCH    = 4;
    localparam int CH_W   = $clog2(NCH);
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int FALL_W = 4;
    localparam int LAST_FALL = 10;

    localparam logic [ADDR_W-1:0] A_DATA = 4'h0;
    localparam logic [ADDR_W-1:0] A_STAT = 4'h2;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'h4;
    localparam logic [ADDR_W-1:0] A_OSIG = 4'h6;
    localparam logic [ADDR_W-1:0] A_ISIG = 4'h8;
    localparam logic [ADDR_W-1:0] A_IEN  = 4'hA;

    localparam logic [BYTE_W-1:0] OSIG_RST  = 8'h47;
    localparam logic [BYTE_W-1:0] CTRL_MASK = 8'hF3;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] osig;
        logic [BYTE_W-1:0] ien;
    } regs_t;

    typedef struct packed {
        logic [NCH-1:0]    prev;
        logic              busy;
        logic              done;
        logic              txm;
        logic [CH_W-1:0]   ch;
        logic [FALL_W-1:0] nfall;
        logic [BYTE_W-1:0] sh;
        logic              par;
        logic              txbit;
        logic              sot;
        logic              eot;
        logic              perr;
        logic              ferr;
        logic              load;
    } eng_t;

    function automatic logic [7:0] pack_sig(input logic [3:0] c, input logic [3:0] d);
        return {c[3], d[3], c[2:0], d[2:0]};
    endfunction

    function automatic logic [3:0] clk_bits(input logic [7:0] s);
        return {s[7], s[5:3]};
    endfunction

    function automatic logic [3:0] dat_bits(input logic [7:0] s);
        return {s[6], s[2:0]};
    endfunction

    function automatic logic [2:0] port_code(input logic [CH_W-1:0] ch);
        return (ch < 2) ? 3'(ch) + 3'd1 : 3'(ch) + 3'd2;
    endfunction
endpackage

// File: rtl/ps2q_filter.sv
module ps2q_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 6,
    parameter int MAX_SEL     = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw,
    input  logic [2:0] sel,
    output logic       sync_o,
    output logic       deb_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sh;
        logic                   deb;
        logic [CNT_W-1:0]       cnt;
    } flt_t;

    flt_t q, d;
    logic [CNT_W:0] limit;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        limit   = (CNT_W+1)'(1) << ((sel > 3'(MAX_SEL)) ? 3'(MAX_SEL) : sel);
        cnt_inc = {1'b0, q.cnt} + 1'b1;
        d       = q;
        d.sh    = {q.sh[SYNC_STAGES-2:0], raw};
        if (q.sh[SYNC_STAGES-1] != q.deb) begin
            if (cnt_inc >= limit) begin
                d.deb = q.sh[SYNC_STAGES-1];
                d.cnt = '0;
            end else begin
                d.cnt = cnt_inc[CNT_W-1:0];
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sh  <= '1;
            q.deb <= 1'b1;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign sync_o = q.sh[SYNC_STAGES-1];
    assign deb_o  = q.deb;

    // R11
    no_short_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.deb != $past(q.deb)) |-> ($past(q.sh[SYNC_STAGES-1]) == q.deb));
endmodule

// File: rtl/ps2q_engine.sv
module ps2q_engine
    import ps2q_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              tx_mode,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic [NCH-1:0]    clk_en,
    input  logic [NCH-1:0]    tx_req,
    input  logic [NCH-1:0]    deb_clk,
    input  logic [NCH-1:0]    deb_dat,
    output logic              sot,
    output logic              eot,
    output logic              perr,
    output logic              ferr,
    output logic [2:0]        ach,
    output logic              rx_load,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [NCH-1:0]    dat_own,
    output logic [NCH-1:0]    dat_low
);
    eng_t q, d;
    logic [NCH-1:0]    fall;
    logic              found;
    logic [CH_W-1:0]   pick;
    logic              bit_in;
    logic [FALL_W-1:0] step;

    always_comb begin
        d      = q;
        d.load = 1'b0;
        d.prev = deb_clk;
        fall   = q.prev & ~deb_clk & clk_en;
        found  = 1'b0;
        pick   = '0;
        for (int c = NCH-1; c >= 0; c--) begin
            if (fall[c] && (tx_mode ? tx_req[c] : !deb_dat[c])) begin
                found = 1'b1;
                pick  = CH_W'(c);
            end
        end
        bit_in = deb_dat[q.ch];
        step   = q.nfall + 1'b1;
        if (hold) begin
            d      = '0;
            d.prev = deb_clk;
        end else if (!q.busy && !q.done) begin
            if (found) begin
                d.busy  = 1'b1;
                d.sot   = 1'b1;
                d.ch    = pick;
                d.nfall = '0;
                d.txm   = tx_mode;
                d.sh    = tx_mode ? (tx_byte >> 1) : '0;
                d.txbit = tx_byte[0];
                d.par   = ~^tx_byte;
            end
        end else if (q.busy && fall[q.ch]) begin
            d.nfall = step;
            if (q.txm) begin
                if (step <= FALL_W'(BYTE_W-1)) begin
                    d.txbit = q.sh[0];
                    d.sh    = q.sh >> 1;
                end else if (step == FALL_W'(BYTE_W)) begin
                    d.txbit = q.par;
                end else begin
                    d.txbit = 1'b1;
                end
            end else begin
                if (step <= FALL_W'(BYTE_W)) begin
                    d.sh = {bit_in, q.sh[BYTE_W-1:1]};
                end else if (step == FALL_W'(BYTE_W+1)) begin
                    d.par = bit_in;
                end
            end
            if (step == FALL_W'(LAST_FALL)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.eot  = 1'b1;
                if (!q.txm) begin
                    d.perr = ~(^q.sh ^ q.par);
                    d.ferr = ~bit_in;
                    d.load = bit_in;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.prev <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            dat_own[c] = (q.busy || q.done) && q.txm && (q.ch == CH_W'(c));
            dat_low[c] = q.busy && q.txm && (q.ch == CH_W'(c)) && !q.txbit;
        end
    end

    assign sot     = q.sot;
    assign eot     = q.eot;
    assign perr    = q.perr;
    assign ferr    = q.ferr;
    assign ach     = q.sot ? port_code(q.ch) : 3'd0;
    assign rx_load = q.load;
    assign rx_byte = q.sh;

    // R7
    sot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sot && !hold) |=> sot);
    // R7
    hold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!sot && !eot && !perr && !ferr));
    // R4
    eot_after_sot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eot |-> sot);
    // R8
    port_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sot && !hold) |=> $stable(ach));
    // R9
    one_port_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dat_own));
endmodule

// File: rtl/ps2q_host.sv
module ps2q_host
    import ps2q_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wen,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [3:0]  ps2_clk_in,
    input  logic [3:0]  ps2_dat_in,
    output logic [3:0]  ps2_clk_low,
    output logic [3:0]  ps2_dat_low,
    output logic        pullup_en,
    output logic        irq
);
    regs_t q, d;
    logic [NCH-1:0]    s_clk, s_dat, f_clk, f_dat;
    logic [NCH-1:0]    clk_en, wdat, own, eng_low;
    logic              hold, sot, eot, perr, ferr, rx_load;
    logic [2:0]        ach;
    logic [BYTE_W-1:0] rx_byte, status;

    for (genvar g = 0; g < NCH; g++) begin : g_in
        ps2q_filter u_cf (.clk(clk), .rst_n(rst_n), .raw(ps2_clk_in[g]),
                          .sel(q.ctrl[6:4]), .sync_o(s_clk[g]), .deb_o(f_clk[g]));
        ps2q_filter u_df (.clk(clk), .rst_n(rst_n), .raw(ps2_dat_in[g]),
                          .sel(q.ctrl[6:4]), .sync_o(s_dat[g]), .deb_o(f_dat[g]));
    end

    assign clk_en = clk_bits(q.osig);
    assign wdat   = dat_bits(q.osig);
    assign hold   = (clk_en == '0) || !q.ctrl[0];

    ps2q_engine u_eng (
        .clk(clk), .rst_n(rst_n), .hold(hold), .tx_mode(q.ctrl[1]),
        .tx_byte(q.data), .clk_en(clk_en), .tx_req(~wdat),
        .deb_clk(f_clk), .deb_dat(f_dat), .sot(sot), .eot(eot),
        .perr(perr), .ferr(ferr), .ach(ach), .rx_load(rx_load),
        .rx_byte(rx_byte), .dat_own(own), .dat_low(eng_low)
    );

    assign status = {1'b0, ferr, ach, perr, eot, sot};

    always_comb begin
        d = q;
        if (reg_wen) begin
            case (reg_addr)
                A_DATA:  d.data = reg_wdata;
                A_CTRL:  d.ctrl = reg_wdata & CTRL_MASK;
                A_OSIG:  d.osig = reg_wdata;
                A_IEN:   d.ien  = reg_wdata;
                default: ;
            endcase
        end
        if (rx_load) d.data = rx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.data <= '0;
            q.ctrl <= '0;
            q.osig <= OSIG_RST;
            q.ien  <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr)
            A_DATA:  reg_rdata = q.data;
            A_STAT:  reg_rdata = status;
            A_CTRL:  reg_rdata = q.ctrl;
            A_OSIG:  reg_rdata = q.osig;
            A_ISIG:  reg_rdata = pack_sig(s_clk, s_dat);
            A_IEN:   reg_rdata = q.ien;
            default: reg_rdata = '0;
        endcase
    end

    assign ps2_clk_low = ~clk_en;
    assign ps2_dat_low = (~wdat & ~own) | eng_low;
    assign pullup_en   = q.ctrl[7];
    assign irq         = (sot & q.ien[0]) | (eot & q.ien[1]);

    // R4
    rx_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> (q.data == $past(rx_byte)));
    // R6
    ferr_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ferr) && !$past(reg_wen)) |-> $stable(q.data));
    // R2
    held_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en == '0) |-> (ps2_clk_low == 4'hF));
endmodule

// File: tb/tb_ps2q_host.sv
module tb_ps2q_host;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_wen = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [3:0] ps2_clk_low, ps2_dat_low;
    logic       pullup_en, irq;
    logic [3:0] dev_clk_low = 4'h0;
    logic [3:0] dev_dat_low = 4'h0;
    logic [3:0] clk_line, dat_line;
    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    assign clk_line = ~(ps2_clk_low | dev_clk_low);
    assign dat_line = ~(ps2_dat_low | dev_dat_low);

    ps2q_host dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ps2_clk_in(clk_line),
        .ps2_dat_in(dat_line), .ps2_clk_low(ps2_clk_low), .ps2_dat_low(ps2_dat_low),
        .pullup_en(pullup_en), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic engine_reset();
        wr(4'h6, 8'h47);
        tick(3);
        wr(4'h6, 8'hFF);
        tick(80);
    endtask

    task automatic send_frame(input logic [3:0] m, input logic [7:0] b,
                              input logic bad_par, input logic bad_stop);
        logic [10:0] f;
        f = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
        for (int i = 0; i < 11; i++) begin
            dev_dat_low = f[i] ? 4'h0 : m;
            tick(20);
            dev_clk_low = m;
            tick(60);
            dev_clk_low = 4'h0;
            tick(40);
        end
        dev_dat_low = 4'h0;
        tick(60);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(4'h2, v); chk("R1 status", v, 8'h00);
        rd(4'h4, v); chk("R1 control", v, 8'h00);
        rd(4'h6, v); chk("R1 outsig", v, 8'h47);
        rd(4'hA, v); chk("R1 ien", v, 8'h00);
        chk("R1 lines", {ps2_clk_low, ps2_dat_low}, 8'hF0);
        chk("R1 irq/pullup", {6'd0, irq, pullup_en}, 8'h00);
    endtask

    task automatic t_insig();
        logic [7:0] v;
        wr(4'h4, 8'h01);
        wr(4'h6, 8'hFF);
        wr(4'hA, 8'h03);
        chk("R2 clocks released", {4'h0, ps2_clk_low}, 8'h00);
        dev_dat_low = 4'b0101;
        tick(6);
        rd(4'h8, v); chk("R3 insig", v, 8'hFA);
        dev_dat_low = 4'h0;
        wr(4'h6, 8'hFE);
        tick(6);
        rd(4'h8, v); chk("R2 data bit pulls low", v, 8'hFE);
        wr(4'h6, 8'hFF);
        tick(60);
    endtask

    task automatic t_rx_basic();
        logic [7:0] v;
        send_frame(4'b0100, 8'hA5, 1'b0, 1'b0);
        rd(4'h2, v); chk("R4 status port2", v, 8'h23);
        rd(4'h0, v); chk("R4 data", v, 8'hA5);
        chk("R10 irq on", {7'd0, irq}, 8'h01);
        send_frame(4'b0001, 8'h3C, 1'b0, 1'b0);
        rd(4'h2, v); chk("R8 status kept", v, 8'h23);
        rd(4'h0, v); chk("R8 data kept", v, 8'hA5);
        engine_reset();
        rd(4'h2, v); chk("R7 cleared", v, 8'h00);
        chk("R10 irq off", {7'd0, irq}, 8'h00);
        send_frame(4'b1000, 8'h00, 1'b0, 1'b0);
        rd(4'h2, v); chk("R4 status port3", v, 8'h2B);
        rd(4'h0, v); chk("R4 data zero", v, 8'h00);
        engine_reset();
    endtask

    task automatic t_errors();
        logic [7:0] v;
        send_frame(4'b0010, 8'h81, 1'b1, 1'b0);
        rd(4'h2, v); chk("R5 parity status", v, 8'h17);
        rd(4'h0, v); chk("R5 data stored", v, 8'h81);
        engine_reset();
        send_frame(4'b0001, 8'h55, 1'b0, 1'b1);
        rd(4'h2, v); chk("R6 frame status", v, 8'h4B);
        rd(4'h0, v); chk("R6 data unchanged", v, 8'h81);
        engine_reset();
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        send_frame(4'b1010, 8'h6E, 1'b0, 1'b0);
        rd(4'h2, v); chk("R8 lowest port", v, 8'h13);
        rd(4'h0, v); chk("R8 data", v, 8'h6E);
        engine_reset();
    endtask

    task automatic t_irq_start();
        logic [7:0] v;
        wr(4'hA, 8'h00);
        send_frame(4'b0001, 8'h11, 1'b0, 1'b0);
        chk("R10 masked", {7'd0, irq}, 8'h00);
        wr(4'hA, 8'h02);
        tick(1);
        chk("R10 end enabled", {7'd0, irq}, 8'h01);
        engine_reset();
        wr(4'hA, 8'h01);
        dev_dat_low = 4'b0010;
        tick(20);
        dev_clk_low = 4'b0010;
        tick(60);
        dev_clk_low = 4'h0;
        dev_dat_low = 4'h0;
        tick(40);
        rd(4'h2, v); chk("R7 start only", v, 8'h11);
        chk("R10 start irq", {7'd0, irq}, 8'h01);
        tick(200);
        rd(4'h2, v); chk("R7 start sticky", v, 8'h11);
        wr(4'h4, 8'h00);
        tick(2);
        rd(4'h2, v); chk("R7 disable clears", v, 8'h00);
        wr(4'h4, 8'h01);
        wr(4'hA, 8'h03);
        engine_reset();
    endtask

    task automatic t_debounce();
        logic [7:0] v;
        wr(4'h4, 8'h51);
        tick(40);
        dev_dat_low = 4'b0001;
        dev_clk_low = 4'b0001;
        tick(10);
        dev_clk_low = 4'h0;
        tick(60);
        dev_dat_low = 4'h0;
        tick(60);
        rd(4'h2, v); chk("R11 glitch ignored", v, 8'h00);
        send_frame(4'b0001, 8'hC3, 1'b0, 1'b0);
        rd(4'h2, v); chk("R11 long frame status", v, 8'h0B);
        rd(4'h0, v); chk("R11 long frame data", v, 8'hC3);
        wr(4'h4, 8'h01);
        engine_reset();
    endtask

    task automatic t_pullup();
        logic [7:0] v;
        wr(4'h4, 8'hFF);
        rd(4'h4, v); chk("R12 reserved zero", v, 8'hF3);
        chk("R12 pullup", {7'd0, pullup_en}, 8'h01);
        wr(4'h4, 8'h01);
        engine_reset();
    endtask

    task automatic t_tx();
        logic [7:0] v;
        logic [9:0] got;
        wr(4'h4, 8'h03);
        wr(4'h0, 8'h96);
        wr(4'h6, 8'hFD);
        tick(4);
        chk("R9 request to send", {4'h0, dat_line}, 8'h0D);
        for (int k = 0; k < 11; k++) begin
            if (k == 10) dev_dat_low = 4'b0010;
            dev_clk_low = 4'b0010;
            tick(40);
            dev_clk_low = 4'h0;
            tick(40);
            if (k < 10) got[k] = dat_line[1];
        end
        dev_dat_low = 4'h0;
        tick(20);
        chk("R9 data bits", got[7:0], 8'h96);
        chk("R9 parity/stop", {6'd0, got[9:8]}, 8'h03);
        rd(4'h2, v); chk("R9 end status", v, 8'h13);
        chk("R9 line released", {7'd0, ps2_dat_low[1]}, 8'h00);
        wr(4'h4, 8'h01);
        engine_reset();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_insig();
        t_rx_basic();
        t_errors();
        t_same_cycle();
        t_irq_start();
        t_debounce();
        t_pullup();
        t_tx();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule